// File: doc/BRIEF.md
# T1 Serial PCM Link Framer

This block joins one T1 line's serial PCM link to a byte-wide, timeslot-indexed parallel side. It runs entirely in the system clock `clk`. The transmit and receive serial clocks and their sync pulses arrive as ordinary inputs. Each one is registered once, and an edge detector turns the chosen serial clock edge into a one-cycle bit strobe. A bit counter on each side tracks the position inside the frame.

The receive side shifts the incoming bits into bytes. The transmit side asks for each byte one bit period before that byte starts and then shifts it out. Both sides skip the positions that carry no payload.

Two frame layouts are supported, chosen by `mode_wide`:

- **Narrow layout (`mode_wide` = 0).** 193 bits per frame. Position 0 is the framing bit and carries no payload. Positions 1 to 192 hold 24 payload bytes.
- **Wide layout (`mode_wide` = 1).** 256 bits, grouped as 32 slots of 8 bits each. The 24 payload channels fill these slots by one of two mappings.

The sample edge, the launch edge and the sync polarity are each set per link.

Each side has a small state machine with two states:

- **HUNT.** Entered at reset. The block ignores the link.
- **RUN.** Entered on the transition HUNT→RUN, which happens at the first strobe that sees an active sync.

In RUN the counter flywheels: it wraps at the end of the frame without needing a sync. Each active sync reloads position 0. The self-transition RUN→RUN is a realign when the sync arrives where the counter did not expect position 0; it then raises a one-cycle misalignment flag.

Top module: `t1_pcm_link`

## Requirements
- R1: `mode_wide` = 0 selects a 193-bit frame and `mode_wide` = 1 selects a 256-bit frame. In both, exactly 24 payload bytes per frame appear on `rx_valid`, with `rx_ch` counting 0 to 23 in order.
- R2: In the narrow layout, the bit that carries the active sync is frame position 0 (the framing bit). It is excluded from receive bytes and is transmitted as 1. Channel c occupies positions 1+8c to 8+8c.
- R3: In the wide layout with `map_spaced` = 0, channel c occupies slot c+1 (bit positions 8(c+1) to 8(c+1)+7). Slots 0 and 25 to 31 are unused.
- R4: In the wide layout with `map_spaced` = 1, slots whose number is a multiple of 4 are unused. Channel c occupies slot c + c/3 + 1 (integer division).
- R5: Unused slots are transmitted as all ones, and their received bits produce no byte.
- R6: Bits travel MSB first. One `clk` cycle after the sample strobe of a payload byte's eighth bit, `rx_valid` is high for exactly one cycle, carrying that byte on `rx_byte` and its channel on `rx_ch`.
- R7: `tx_req` is a one-cycle pulse, with `tx_req_ch`, issued during the bit period just before a channel's first bit. `tx_byte` is captured when that first bit is launched.
- R8: `tx_edge_fall` and `rx_edge_fall` each select the falling (1) or rising (0) serial clock edge, for launching transmit bits and for sampling receive bits respectively.
- R9: `sync_inv` = 1 makes both sync inputs active low; with 0 they are active high.
- R10: After reset and until the first active sync, `tx_sdata` stays 1, and neither `rx_valid` nor `tx_req` is raised.
- R11: Once framed, a side keeps its position across frames that carry no sync pulse.
- R12: A sync pulse at any position other than the expected position 0 raises that side's misalignment flag for exactly one cycle and restarts the count at position 0. Correct bytes follow from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_wide | input | 1 | 0: 193-bit frame, 1: 256-bit frame |
| map_spaced | input | 1 | Wide layout channel mapping, 0 grouped, 1 spaced |
| tx_edge_fall | input | 1 | Launch transmit bits on the falling serial clock edge |
| rx_edge_fall | input | 1 | Sample receive bits on the falling serial clock edge |
| sync_inv | input | 1 | Sync inputs active low when 1 |
| tx_sclk | input | 1 | Transmit serial clock |
| tx_sync | input | 1 | Transmit frame sync |
| tx_byte | input | 8 | Byte for the channel last requested |
| tx_sdata | output | 1 | Transmit serial data |
| tx_req | output | 1 | Byte request pulse |
| tx_req_ch | output | 5 | Channel of the requested byte |
| tx_misalign | output | 1 | Transmit sync misalignment pulse |
| rx_sclk | input | 1 | Receive serial clock |
| rx_sync | input | 1 | Receive frame sync |
| rx_sdata | input | 1 | Receive serial data |
| rx_valid | output | 1 | Received byte strobe |
| rx_ch | output | 5 | Channel of the received byte |
| rx_byte | output | 8 | Received byte |
| rx_misalign | output | 1 | Receive sync misalignment pulse |

## Verification

The serial pins settle after a serial edge is registered. One `clk` cycle later that edge becomes a strobe, so `tx_sdata` and `tx_req` change two cycles after the launch edge. The bench samples `tx_sdata` three cycles after that edge, which still falls inside the first half of the bit. `rx_valid` and the misalignment flags rise two cycles after the sampling edge, which is two cycles before the next serial edge. The bench therefore logs them in a monitor and evaluates the log only once the whole bit, or frame, has been driven. The bench tracks its own frame position for each driven bit, and each `tx_req` is checked against the bit period that is current when the pulse occurs.

// File: rtl/pcm_t1_pkg.sv
package pcm_t1_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_W     = $clog2(BYTE_W);
    localparam int POS_W     = 8;
    localparam int CH_W      = 5;
    localparam int N_CH      = 24;
    localparam int T1_BITS   = 193;
    localparam int WIDE_BITS = 256;
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

    typedef enum logic [0:0] {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } link_st_e;

    typedef struct packed {
        logic             used;
        logic [CH_W-1:0]  ch;
        logic [BIT_W-1:0] bitn;
    } slot_info_t;

    function automatic logic [POS_W-1:0] frame_last(input logic wide);
        return wide ? POS_W'(WIDE_BITS - 1) : POS_W'(T1_BITS - 1);
    endfunction

    // Translate a frame bit position into channel, bit index and usage.
    function automatic slot_info_t map_pos(input logic wide, input logic spaced,
                                           input logic [POS_W-1:0] pos);
        slot_info_t      r;
        logic [POS_W-1:0] q;
        logic [CH_W-1:0]  s;
        r = '0;
        q = pos - POS_W'(1);
        s = pos[POS_W-1:BIT_W];
        if (!wide) begin
            r.used = (pos != '0);
            r.ch   = q[POS_W-1:BIT_W];
            r.bitn = q[BIT_W-1:0];
        end else begin
            r.bitn = pos[BIT_W-1:0];
            if (spaced) begin
                r.used = (s[1:0] != 2'b00);
                r.ch   = s - CH_W'(s[CH_W-1:2]) - CH_W'(1);
            end else begin
                r.used = (s != '0) && (s <= CH_W'(N_CH));
                r.ch   = s - CH_W'(1);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pcm_edge_pick.sv
module pcm_edge_pick (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sync,
    input  logic fall_sel,
    input  logic sync_inv,
    output logic strobe,
    output logic sync_act
);
    logic sclk_q;
    logic sclk_q2;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sclk_q2 <= 1'b0;
            sync_q  <= 1'b0;
        end else begin
            sclk_q  <= sclk;
            sclk_q2 <= sclk_q;
            sync_q  <= sync;
        end
    end

    always_comb begin
        strobe   = fall_sel ? (!sclk_q && sclk_q2) : (sclk_q && !sclk_q2);
        sync_act = sync_q ^ sync_inv;
    end

    // R8
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr
    import pcm_t1_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             sync_act,
    input  logic             wide,
    output logic [POS_W-1:0] cur_pos,
    output logic             active,
    output logic             misalign
);
    link_st_e         st_q;
    link_st_e         st_d;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] wrap_nxt;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HUNT: if (strobe && sync_act) st_d = ST_RUN;
            ST_RUN:  st_d = ST_RUN;
        endcase
    end

    always_comb begin
        wrap_nxt = (pos_q >= frame_last(wide)) ? '0 : pos_q + POS_W'(1);
        cur_pos  = sync_act ? '0 : wrap_nxt;
        active   = strobe && ((st_q == ST_RUN) || sync_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HUNT;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q    <= '0;
            misalign <= 1'b0;
        end else begin
            if (active) pos_q <= cur_pos;
            misalign <= strobe && sync_act && (st_q == ST_RUN) && (wrap_nxt != '0);
        end
    end

    // R12
    misalign_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |=> !misalign);

    // R11
    run_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN) |=> (st_q == ST_RUN));

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
    import pcm_t1_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [POS_W-1:0]  cur_pos,
    input  logic              wide,
    input  logic              spaced,
    input  logic              sdata,
    output logic              rx_valid,
    output logic [CH_W-1:0]   rx_ch,
    output logic [BYTE_W-1:0] rx_byte
);
    slot_info_t        info;
    logic              sdata_q;
    logic [BYTE_W-2:0] sh;

    always_comb info = map_pos(wide, spaced, cur_pos);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdata_q  <= 1'b0;
            sh       <= '0;
            rx_valid <= 1'b0;
            rx_ch    <= '0;
            rx_byte  <= '0;
        end else begin
            sdata_q  <= sdata;
            rx_valid <= 1'b0;
            if (active && info.used) begin
                if (info.bitn == BIT_W'(BYTE_W - 1)) begin
                    rx_valid <= 1'b1;
                    rx_byte  <= {sh, sdata_q};
                    rx_ch    <= info.ch;
                end else begin
                    sh <= {sh[BYTE_W-3:0], sdata_q};
                end
            end
        end
    end

    // R6
    rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    rx_ch_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (rx_ch <= LAST_CH));

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
    import pcm_t1_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [POS_W-1:0]  cur_pos,
    input  logic              wide,
    input  logic              spaced,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_sdata,
    output logic              tx_req,
    output logic [CH_W-1:0]   tx_req_ch
);
    slot_info_t        info_c;
    slot_info_t        info_n;
    logic [POS_W-1:0]  nxt_pos;
    logic [BYTE_W-1:0] hold;

    always_comb begin
        nxt_pos = (cur_pos >= frame_last(wide)) ? '0 : cur_pos + POS_W'(1);
        info_c  = map_pos(wide, spaced, cur_pos);
        info_n  = map_pos(wide, spaced, nxt_pos);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sdata  <= 1'b1;
            hold      <= '1;
            tx_req    <= 1'b0;
            tx_req_ch <= '0;
        end else begin
            tx_req <= 1'b0;
            if (active) begin
                tx_req    <= info_n.used && (info_n.bitn == '0);
                tx_req_ch <= info_n.ch;
                if (!info_c.used) begin
                    tx_sdata <= 1'b1;
                end else if (info_c.bitn == '0) begin
                    tx_sdata <= tx_byte[BYTE_W-1];
                    hold     <= {tx_byte[BYTE_W-2:0], 1'b1};
                end else begin
                    tx_sdata <= hold[BYTE_W-1];
                    hold     <= {hold[BYTE_W-2:0], 1'b1};
                end
            end
        end
    end

    // R7
    tx_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    // R7
    tx_req_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> (tx_req_ch <= LAST_CH));

endmodule

// File: rtl/t1_pcm_link.sv
module t1_pcm_link
    import pcm_t1_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wide,
    input  logic              map_spaced,
    input  logic              tx_edge_fall,
    input  logic              rx_edge_fall,
    input  logic              sync_inv,
    input  logic              tx_sclk,
    input  logic              tx_sync,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_sdata,
    output logic              tx_req,
    output logic [CH_W-1:0]   tx_req_ch,
    output logic              tx_misalign,
    input  logic              rx_sclk,
    input  logic              rx_sync,
    input  logic              rx_sdata,
    output logic              rx_valid,
    output logic [CH_W-1:0]   rx_ch,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_misalign
);
    logic             tx_stb, tx_sy, tx_act;
    logic             rx_stb, rx_sy, rx_act;
    logic [POS_W-1:0] tx_pos, rx_pos;

    pcm_edge_pick u_tx_edge (
        .clk(clk), .rst_n(rst_n), .sclk(tx_sclk), .sync(tx_sync),
        .fall_sel(tx_edge_fall), .sync_inv(sync_inv),
        .strobe(tx_stb), .sync_act(tx_sy)
    );

    pcm_frame_ctr u_tx_ctr (
        .clk(clk), .rst_n(rst_n), .strobe(tx_stb), .sync_act(tx_sy),
        .wide(mode_wide), .cur_pos(tx_pos), .active(tx_act),
        .misalign(tx_misalign)
    );

    pcm_tx_path u_tx (
        .clk(clk), .rst_n(rst_n), .active(tx_act), .cur_pos(tx_pos),
        .wide(mode_wide), .spaced(map_spaced), .tx_byte(tx_byte),
        .tx_sdata(tx_sdata), .tx_req(tx_req), .tx_req_ch(tx_req_ch)
    );

    pcm_edge_pick u_rx_edge (
        .clk(clk), .rst_n(rst_n), .sclk(rx_sclk), .sync(rx_sync),
        .fall_sel(rx_edge_fall), .sync_inv(sync_inv),
        .strobe(rx_stb), .sync_act(rx_sy)
    );

    pcm_frame_ctr u_rx_ctr (
        .clk(clk), .rst_n(rst_n), .strobe(rx_stb), .sync_act(rx_sy),
        .wide(mode_wide), .cur_pos(rx_pos), .active(rx_act),
        .misalign(rx_misalign)
    );

    pcm_rx_path u_rx (
        .clk(clk), .rst_n(rst_n), .active(rx_act), .cur_pos(rx_pos),
        .wide(mode_wide), .spaced(map_spaced), .sdata(rx_sdata),
        .rx_valid(rx_valid), .rx_ch(rx_ch), .rx_byte(rx_byte)
    );

endmodule

// File: tb/sim_t1_pcm_link.sv
module sim_t1_pcm_link;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam logic [7:0] TX_SEED = 8'hA5;
    localparam logic [7:0] RX_SEED = 8'h3C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wide = 1'b0, spaced = 1'b0, tx_fall = 1'b1, rx_fall = 1'b0, sinv = 1'b0;
    logic       sclk = 1'b1, sync_pin = 1'b0, rx_d = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_sdata, tx_req, tx_mis, rx_valid, rx_mis;
    logic [4:0] tx_req_ch, rx_ch;
    logic [7:0] rx_byte;

    int checks = 0, errors = 0;
    int bp = 0;
    bit locked = 0;
    int ev_n = 0, req_n = 0, req_bad = 0, mis_rx = 0, mis_tx = 0, tx_bad = 0, hunt_bad = 0;
    logic [4:0] ev_ch [0:63];
    logic [7:0] ev_b  [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    t1_pcm_link u0 (
        .clk(clk), .rst_n(rst_n), .mode_wide(wide), .map_spaced(spaced),
        .tx_edge_fall(tx_fall), .rx_edge_fall(rx_fall), .sync_inv(sinv),
        .tx_sclk(sclk), .tx_sync(sync_pin), .tx_byte(tx_byte),
        .tx_sdata(tx_sdata), .tx_req(tx_req), .tx_req_ch(tx_req_ch),
        .tx_misalign(tx_mis), .rx_sclk(sclk), .rx_sync(sync_pin),
        .rx_sdata(rx_d), .rx_valid(rx_valid), .rx_ch(rx_ch),
        .rx_byte(rx_byte), .rx_misalign(rx_mis)
    );

    function automatic logic [7:0] pat(input logic [7:0] seed, input int ch);
        return seed ^ 8'(ch * 29 + 7);
    endfunction

    function automatic int frame_len();
        return wide ? 256 : 193;
    endfunction

    function automatic int first_pos(input int ch);
        if (!wide)   return 1 + 8 * ch;
        if (!spaced) return 8 * (ch + 1);
        return 8 * (ch + ch / 3 + 1);
    endfunction

    function automatic logic exp_bit(input logic [7:0] seed, input int p, input logic idle);
        for (int ch = 0; ch < 24; ch++) begin
            int fp;
            logic [7:0] b;
            fp = first_pos(ch);
            if (p >= fp && p < fp + 8) begin
                b = pat(seed, ch);
                return b[7 - (p - fp)];
            end
        end
        return idle;
    endfunction

    always @(posedge clk) begin
        if (rx_valid) begin
            if (ev_n < 64) begin
                ev_ch[ev_n] <= rx_ch;
                ev_b[ev_n]  <= rx_byte;
            end
            ev_n <= ev_n + 1;
        end
        if (tx_req) begin
            req_n <= req_n + 1;
            if (first_pos(int'(tx_req_ch)) - 1 != bp) req_bad <= req_bad + 1;
            tx_byte <= pat(TX_SEED, int'(tx_req_ch));
        end
        if (rx_mis) mis_rx <= mis_rx + 1;
        if (tx_mis) mis_tx <= mis_tx + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_logs();
        @(negedge clk);
        ev_n = 0; req_n = 0; req_bad = 0; mis_rx = 0; mis_tx = 0; tx_bad = 0; hunt_bad = 0;
    endtask

    task automatic do_reset(input logic w, input logic sp, input logic txf, input logic inv);
        @(negedge clk);
        rst_n = 1'b0;
        wide = w; spaced = sp; tx_fall = txf; rx_fall = ~txf; sinv = inv;
        sclk = txf; sync_pin = inv; rx_d = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        locked = 0; bp = 0;
        clear_logs();
    endtask

    task automatic drive_bit(input bit s);
        @(negedge clk);
        if (s) begin
            bp = 0;
            locked = 1;
        end else begin
            bp = (bp >= frame_len() - 1) ? 0 : bp + 1;
        end
        sclk     = ~tx_fall;
        sync_pin = s ^ sinv;
        rx_d     = exp_bit(RX_SEED, bp, 1'b0);
        repeat (HALF - 1) @(negedge clk);
        if (locked) begin
            if (tx_sdata !== exp_bit(TX_SEED, bp, 1'b1)) tx_bad++;
        end else if (tx_sdata !== 1'b1) begin
            hunt_bad++;
        end
        @(negedge clk);
        sclk = tx_fall;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic frame(input int nbits, input bit with_sync);
        for (int i = 0; i < nbits; i++) drive_bit(with_sync && i == 0);
    endtask

    task automatic check_events(input string tag);
        int bad;
        bad = 0;
        check(ev_n == 24, {tag, " byte count"}, ev_n, 24);
        for (int i = 0; i < 24 && i < ev_n; i++)
            if (ev_ch[i] != 5'(i) || ev_b[i] != pat(RX_SEED, i)) bad++;
        check(bad == 0, {tag, " channel/byte order"}, bad, 0);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b0, 1'b1, 1'b0);
        check(tx_sdata === 1'b1, "R10 tx idle after reset", int'(tx_sdata), 1);
        check(!rx_valid && !tx_req && !rx_mis && !tx_mis, "R10 outputs quiet after reset",
              int'({rx_valid, tx_req, rx_mis, tx_mis}), 0);
    endtask

    task automatic t_hunt();
        do_reset(1'b0, 1'b0, 1'b1, 1'b0);
        frame(60, 1'b0);
        check(ev_n == 0, "R10 no rx bytes before sync", ev_n, 0);
        check(req_n == 0, "R10 no tx requests before sync", req_n, 0);
        check(hunt_bad == 0, "R10 tx stays high before sync", hunt_bad, 0);
    endtask

    task automatic t_narrow();
        do_reset(1'b0, 1'b0, 1'b1, 1'b0);
        frame(193, 1'b1);
        clear_logs();
        frame(193, 1'b1);
        check_events("R1 R2 R6 narrow rx");
        check(tx_bad == 0, "R2 narrow tx bits incl framing=1", tx_bad, 0);
        check(req_n == 24 && req_bad == 0, "R7 narrow requests", req_n * 100 + req_bad, 2400);
        check(mis_rx + mis_tx == 0, "R12 no misalign on aligned sync", mis_rx + mis_tx, 0);
        clear_logs();
        frame(193, 1'b0);
        check_events("R11 flywheel rx");
        check(tx_bad == 0, "R11 flywheel tx", tx_bad, 0);
    endtask

    task automatic t_slip();
        do_reset(1'b0, 1'b0, 1'b1, 1'b0);
        frame(193, 1'b1);
        frame(100, 1'b1);
        clear_logs();
        frame(193, 1'b1);
        check(mis_rx == 1, "R12 rx misalign one cycle", mis_rx, 1);
        check(mis_tx == 1, "R12 tx misalign one cycle", mis_tx, 1);
        check_events("R12 realigned rx");
        check(tx_bad == 0, "R12 realigned tx", tx_bad, 0);
    endtask

    task automatic t_grouped();
        do_reset(1'b1, 1'b0, 1'b0, 1'b1);
        frame(256, 1'b1);
        clear_logs();
        frame(256, 1'b1);
        check_events("R3 R8 R9 grouped rx");
        check(tx_bad == 0, "R3 R5 R8 grouped tx", tx_bad, 0);
        check(req_n == 24 && req_bad == 0, "R7 grouped requests", req_n * 100 + req_bad, 2400);
        check(mis_rx + mis_tx == 0, "R9 inverted sync aligned", mis_rx + mis_tx, 0);
    endtask

    task automatic t_spaced();
        do_reset(1'b1, 1'b1, 1'b1, 1'b0);
        frame(256, 1'b1);
        clear_logs();
        frame(256, 1'b1);
        check_events("R4 R1 spaced rx");
        check(tx_bad == 0, "R4 R5 spaced tx", tx_bad, 0);
        check(req_n == 24 && req_bad == 0, "R7 spaced requests", req_n * 100 + req_bad, 2400);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_hunt();
        t_narrow();
        t_slip();
        t_grouped();
        t_spaced();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule